// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps the stores that a core has decoded but not yet retired in a ring of slots. Decode claims slots in program order. Each store then fills its slot in two independent steps: an address micro-op writes the target address, and a data micro-op writes the value. Either step may come first. When the retirement logic says the oldest uncommitted store may retire, and that store has both halves, its entry stops being speculative. Committed entries then drain to the data cache, oldest first, under a valid/ready handshake.

A pipeline flush either keeps every entry up to a named slot and discards the younger ones, or discards everything that is still speculative. Entries that have already committed always survive a flush and keep draining.

Loads look the buffer up with their address and an age stamp. The age stamp is the allocation position that was current when the load was decoded. The buffer returns the value of the youngest store that is older than the load and has the same full address. If that answer is not yet safe, it reports that the load is not ready.

Top module: `spec_store_buf`

## Requirements
- R1: After reset the buffer is empty: `dc_wr_valid` is 0, an allocation request is granted with slot 0, and any load reports ready with no hit.
- R2: Each granted allocation returns the next slot index in ring order (0, 1, …, DEPTH-1, 0, …). `alloc_pos` carries one extra wrap bit above the slot index. When DEPTH entries are held, whether committed or not, `alloc_gnt` stays 0.
- R3: The address write and the data write to a slot are accepted in either order. A write to a slot that is not both live and speculative has no effect.
- R4: A `cmt_req` commits the oldest uncommitted entry only if that entry has both its address and its data. Otherwise the request has no effect. A commit becomes visible as a drain request on the following cycle.
- R5: `dc_wr_valid` is high exactly when the oldest entry has committed, and `dc_wr_addr`/`dc_wr_data` carry that entry. A cycle with valid and ready removes the entry.
- R6: An abort with `abort_all`=0 keeps every entry from the oldest up to slot `abort_keep` and discards the younger ones. The next allocation then gets slot `abort_keep`+1, with its address unknown.
- R7: An abort with `abort_all`=1 discards every speculative entry. Committed entries remain, still drain, and still forward.
- R8: A load forwards `ld_data` from the youngest store that is older than the load and has an equal address. Committed entries that have not yet drained take part.
- R9: Stores at or younger than the load's age stamp `ld_pos` never affect the lookup.
- R10: `ld_ready` is 0 if any older store has an unknown address, or if the youngest older matching store lacks its data.
- R11: With no older matching store and no older unknown address, `ld_ready` is 1 and `ld_hit` is 0.
- R12: In a cycle with `abort_req` high, `alloc_gnt` is 0 and no commit happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_gnt | output | 1 | Slot granted this cycle |
| alloc_slot | output | IW | Slot index the next allocation receives |
| alloc_pos | output | IW+1 | Allocation position with wrap bit, used as the age stamp of later loads |
| sa_we | input | 1 | Store-address micro-op write |
| sa_slot | input | IW | Slot written by the address micro-op |
| sa_addr | input | AW | Store address |
| sd_we | input | 1 | Store-data micro-op write |
| sd_slot | input | IW | Slot written by the data micro-op |
| sd_data | input | DW | Store value |
| cmt_req | input | 1 | Oldest uncommitted store may retire |
| abort_req | input | 1 | Flush request |
| abort_all | input | 1 | 1: drop all speculative entries; 0: keep up to `abort_keep` |
| abort_keep | input | IW | Youngest surviving slot |
| dc_wr_valid | output | 1 | Committed entry offered to the cache |
| dc_wr_ready | input | 1 | Cache accepts the offered entry |
| dc_wr_addr | output | AW | Address of the offered entry |
| dc_wr_data | output | DW | Data of the offered entry |
| ld_addr | input | AW | Load address |
| ld_pos | input | IW+1 | Load age stamp (value of `alloc_pos` when the load was decoded) |
| ld_ready | output | 1 | Lookup result is safe to use |
| ld_hit | output | 1 | Forwarded data valid |
| ld_data | output | DW | Forwarded value |

## Verification
The lookup is tried with several buffer states and loads. One older store has a single match. Two older stores share an address, which separates youngest-older from oldest selection. Matching stores lie at or beyond the load's stamp, which shows that the age window is honoured. Older entries have unknown addresses or missing data, which separates "not ready" from "miss". Entries that are committed but not yet drained still supply data.

Commit is tried with an incomplete head entry and a complete one. Drain is tried with the cache refusing and then accepting. Aborts are tried with a kept slot, with the flush-all form, and at the same time as an allocation. Each of these shows whether pointers and live bits move together.

// File: rtl/ssb_pkg.sv
`timescale 1ns/1ps
package ssb_pkg;

    // Per-slot status bits
    typedef struct packed {
        logic live;    // slot holds a store
        logic spec;    // store not yet committed
        logic a_ok;    // address micro-op has written
        logic d_ok;    // data micro-op has written
    } slot_flags_t;

    typedef enum logic [1:0] {
        KILL_NONE = 2'd0,
        KILL_KEEP = 2'd1,
        KILL_ALL  = 2'd2
    } kill_mode_e;

    // Distance from ring position 'from' forward to 'to' in a power-of-two ring
    function automatic int unsigned ring_dist(input int unsigned from,
                                              input int unsigned to,
                                              input int unsigned depth);
        return (to + depth - from) & (depth - 1);
    endfunction

endpackage

// File: rtl/ssb_ptrs.sv
`timescale 1ns/1ps
module ssb_ptrs
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_fire,
    input  logic                       commit_fire,
    input  logic                       drain_fire,
    input  kill_mode_e                 kill_mode,
    input  logic [$clog2(DEPTH)-1:0]   keep_slot,
    output logic [$clog2(DEPTH):0]     head_q,
    output logic [$clog2(DEPTH):0]     cmt_q,
    output logic [$clog2(DEPTH):0]     tail_q,
    output logic [$clog2(DEPTH):0]     kill_cnt,
    output logic                       full,
    output logic                       empty
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [PW-1:0] tail_d;

    assign empty = (tail_q == head_q);
    assign full  = (tail_q[IW-1:0] == head_q[IW-1:0]) && (tail_q[IW] != head_q[IW]);

    // Number of entries, counted from the oldest, that survive an abort
    always_comb begin
        unique case (kill_mode)
            KILL_ALL:  kill_cnt = cmt_q - head_q;
            KILL_KEEP: kill_cnt = PW'(ring_dist(int'(head_q[IW-1:0]), int'(keep_slot), DEPTH) + 1);
            default:   kill_cnt = tail_q - head_q;
        endcase
    end

    always_comb begin
        tail_d = tail_q;
        if (kill_mode != KILL_NONE) tail_d = head_q + kill_cnt;
        else if (alloc_fire)        tail_d = tail_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            cmt_q  <= '0;
            tail_q <= '0;
        end else begin
            tail_q <= tail_d;
            if (commit_fire) cmt_q  <= cmt_q + PW'(1);
            if (drain_fire)  head_q <= head_q + PW'(1);
        end
    end

    AST_OCCUPANCY_BOUND: assert property (@(posedge clk) disable iff (rst)
        (PW'(tail_q - head_q) <= PW'(DEPTH))) else $error("occupancy exceeds depth"); // R2

    AST_COMMIT_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (PW'(cmt_q - head_q) <= PW'(tail_q - head_q))) else $error("commit pointer outside ring"); // R4

    AST_KEEP_TAIL: assert property (@(posedge clk) disable iff (rst)
        (kill_mode == KILL_KEEP) |=> (tail_q[IW-1:0] == IW'($past(keep_slot) + 1'b1))) else $error("abort tail wrong"); // R6

endmodule

// File: rtl/ssb_fwd.sv
`timescale 1ns/1ps
module ssb_fwd
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic [$clog2(DEPTH)-1:0]   head_idx,
    input  slot_flags_t                flags [DEPTH],
    input  logic [AW-1:0]              addr_arr [DEPTH],
    input  logic [DW-1:0]              data_arr [DEPTH],
    input  logic [AW-1:0]              ld_addr,
    input  logic [$clog2(DEPTH):0]     older_cnt,
    output logic                       ld_ready,
    output logic                       ld_hit,
    output logic [DW-1:0]              ld_data
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic          unknown;
    logic          found;
    logic          found_dok;
    logic [DW-1:0] found_data;
    logic [IW-1:0] slot;

    // Walk from oldest to youngest; later matches overwrite earlier ones
    always_comb begin
        unknown    = 1'b0;
        found      = 1'b0;
        found_dok  = 1'b0;
        found_data = '0;
        slot       = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = IW'(int'(head_idx) + k);
            if ((PW'(k) < older_cnt) && flags[slot].live) begin
                if (!flags[slot].a_ok) begin
                    unknown = 1'b1;
                end else if (addr_arr[slot] == ld_addr) begin
                    found      = 1'b1;
                    found_dok  = flags[slot].d_ok;
                    found_data = data_arr[slot];
                end
            end
        end
    end

    assign ld_ready = !unknown && !(found && !found_dok);
    assign ld_hit   = ld_ready && found;
    assign ld_data  = ld_hit ? found_data : '0;

endmodule

// File: rtl/spec_store_buf.sv
`timescale 1ns/1ps
module spec_store_buf
    import ssb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_req,
    output logic                       alloc_gnt,
    output logic [$clog2(DEPTH)-1:0]   alloc_slot,
    output logic [$clog2(DEPTH):0]     alloc_pos,
    input  logic                       sa_we,
    input  logic [$clog2(DEPTH)-1:0]   sa_slot,
    input  logic [AW-1:0]              sa_addr,
    input  logic                       sd_we,
    input  logic [$clog2(DEPTH)-1:0]   sd_slot,
    input  logic [DW-1:0]              sd_data,
    input  logic                       cmt_req,
    input  logic                       abort_req,
    input  logic                       abort_all,
    input  logic [$clog2(DEPTH)-1:0]   abort_keep,
    output logic                       dc_wr_valid,
    input  logic                       dc_wr_ready,
    output logic [AW-1:0]              dc_wr_addr,
    output logic [DW-1:0]              dc_wr_data,
    input  logic [AW-1:0]              ld_addr,
    input  logic [$clog2(DEPTH):0]     ld_pos,
    output logic                       ld_ready,
    output logic                       ld_hit,
    output logic [DW-1:0]              ld_data
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    initial begin
        if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
            $error("DEPTH must be a power of two of at least 2");
    end

    slot_flags_t   flags    [DEPTH];
    logic [AW-1:0] addr_arr [DEPTH];
    logic [DW-1:0] data_arr [DEPTH];

    logic [PW-1:0] head_q, cmt_q, tail_q, kill_cnt;
    logic          full, empty;
    logic          alloc_fire, commit_fire, drain_fire;
    kill_mode_e    kill_mode;
    logic [IW-1:0] head_idx, cmt_idx, tail_idx;

    assign head_idx = head_q[IW-1:0];
    assign cmt_idx  = cmt_q[IW-1:0];
    assign tail_idx = tail_q[IW-1:0];

    assign kill_mode   = !abort_req ? KILL_NONE : (abort_all ? KILL_ALL : KILL_KEEP);
    assign alloc_gnt   = alloc_req && !full && !abort_req;
    assign alloc_fire  = alloc_gnt;
    assign commit_fire = cmt_req && !abort_req && (cmt_q != tail_q)
                         && flags[cmt_idx].a_ok && flags[cmt_idx].d_ok;
    assign dc_wr_valid = (head_q != cmt_q);
    assign drain_fire  = dc_wr_valid && dc_wr_ready;
    assign dc_wr_addr  = addr_arr[head_idx];
    assign dc_wr_data  = data_arr[head_idx];
    assign alloc_slot  = tail_idx;
    assign alloc_pos   = tail_q;

    ssb_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk         (clk),
        .rst         (rst),
        .alloc_fire  (alloc_fire),
        .commit_fire (commit_fire),
        .drain_fire  (drain_fire),
        .kill_mode   (kill_mode),
        .keep_slot   (abort_keep),
        .head_q      (head_q),
        .cmt_q       (cmt_q),
        .tail_q      (tail_q),
        .kill_cnt    (kill_cnt),
        .full        (full),
        .empty       (empty)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PW-1:0] age;
        logic          writable;
        assign age      = PW'(ring_dist(int'(head_idx), i, DEPTH));
        assign writable = flags[i].live && flags[i].spec;

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i]    <= '0;
                addr_arr[i] <= '0;
                data_arr[i] <= '0;
            end else begin
                if (alloc_fire && tail_idx == IW'(i)) begin
                    flags[i] <= '{live: 1'b1, spec: 1'b1, a_ok: 1'b0, d_ok: 1'b0};
                end
                if (sa_we && sa_slot == IW'(i) && writable) begin
                    addr_arr[i]   <= sa_addr;
                    flags[i].a_ok <= 1'b1;
                end
                if (sd_we && sd_slot == IW'(i) && writable) begin
                    data_arr[i]   <= sd_data;
                    flags[i].d_ok <= 1'b1;
                end
                if (commit_fire && cmt_idx == IW'(i)) begin
                    flags[i].spec <= 1'b0;
                end
                if (drain_fire && head_idx == IW'(i)) begin
                    flags[i].live <= 1'b0;
                end
                if (kill_mode != KILL_NONE && writable && age >= kill_cnt) begin
                    flags[i].live <= 1'b0;
                end
            end
        end
    end

    ssb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_fwd (
        .head_idx  (head_idx),
        .flags     (flags),
        .addr_arr  (addr_arr),
        .data_arr  (data_arr),
        .ld_addr   (ld_addr),
        .older_cnt (PW'(ld_pos - head_q)),
        .ld_ready  (ld_ready),
        .ld_hit    (ld_hit),
        .ld_data   (ld_data)
    );

    AST_DRAIN_COMMITTED: assert property (@(posedge clk) disable iff (rst)
        dc_wr_valid |-> (flags[head_idx].live && !flags[head_idx].spec)) else $error("drain of uncommitted entry"); // R5

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (dc_wr_valid && dc_wr_ready) |=> (head_q == $past(head_q) + PW'(1))) else $error("drain did not advance"); // R5

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        empty |-> !dc_wr_valid) else $error("drain from empty buffer"); // R1

    AST_ABORT_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (tail_q == $past(head_q) + $past(kill_cnt))) else $error("allocation during abort"); // R12

endmodule

// File: tb/test_spec_store_buf.sv
`timescale 1ns/1ps
module test_spec_store_buf;
    localparam int DEPTH = 8;
    localparam int IW    = 3;
    localparam int PW    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          alloc_req = 0, alloc_gnt;
    logic [IW-1:0] alloc_slot;
    logic [PW-1:0] alloc_pos;
    logic          sa_we = 0, sd_we = 0;
    logic [IW-1:0] sa_slot = 0, sd_slot = 0;
    logic [31:0]   sa_addr = 0, sd_data = 0;
    logic          cmt_req = 0, abort_req = 0, abort_all = 0;
    logic [IW-1:0] abort_keep = 0;
    logic          dc_wr_valid, dc_wr_ready = 0;
    logic [31:0]   dc_wr_addr, dc_wr_data;
    logic [31:0]   ld_addr = 0;
    logic [PW-1:0] ld_pos = 0;
    logic          ld_ready, ld_hit;
    logic [31:0]   ld_data;

    spec_store_buf #(.DEPTH(DEPTH), .AW(32), .DW(32)) i_spec_store_buf (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_slot(alloc_slot), .alloc_pos(alloc_pos),
        .sa_we(sa_we), .sa_slot(sa_slot), .sa_addr(sa_addr),
        .sd_we(sd_we), .sd_slot(sd_slot), .sd_data(sd_data),
        .cmt_req(cmt_req), .abort_req(abort_req), .abort_all(abort_all), .abort_keep(abort_keep),
        .dc_wr_valid(dc_wr_valid), .dc_wr_ready(dc_wr_ready),
        .dc_wr_addr(dc_wr_addr), .dc_wr_data(dc_wr_data),
        .ld_addr(ld_addr), .ld_pos(ld_pos),
        .ld_ready(ld_ready), .ld_hit(ld_hit), .ld_data(ld_data)
    );

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [1:0]  ph;
        logic [31:0] a;
        logic [3:0]  pos;
        logic        rdy;
        logic        hit;
        logic [31:0] d;
        logic [3:0]  req;
    } ld_vec_t;

    localparam ld_vec_t TBL [10] = '{
        '{ph: 2'd0, a: 32'h100, pos: 4'd1, rdy: 1'b1, hit: 1'b1, d: 32'h11, req: 4'd8},  // R8 single older match
        '{ph: 2'd0, a: 32'h200, pos: 4'd1, rdy: 1'b1, hit: 1'b0, d: 32'h0,  req: 4'd9},  // R9 match is younger
        '{ph: 2'd0, a: 32'h300, pos: 4'd3, rdy: 1'b1, hit: 1'b0, d: 32'h0,  req: 4'd11}, // R11 no match
        '{ph: 2'd0, a: 32'h100, pos: 4'd3, rdy: 1'b0, hit: 1'b0, d: 32'h0,  req: 4'd10}, // R10 youngest match lacks data
        '{ph: 2'd0, a: 32'h200, pos: 4'd3, rdy: 1'b1, hit: 1'b1, d: 32'h22, req: 4'd8},  // R8 data-first store
        '{ph: 2'd0, a: 32'h200, pos: 4'd4, rdy: 1'b0, hit: 1'b0, d: 32'h0,  req: 4'd10}, // R10 older unknown address
        '{ph: 2'd0, a: 32'h100, pos: 4'd0, rdy: 1'b1, hit: 1'b0, d: 32'h0,  req: 4'd9},  // R9 nothing older
        '{ph: 2'd1, a: 32'h100, pos: 4'd4, rdy: 1'b1, hit: 1'b1, d: 32'h44, req: 4'd8},  // R8 youngest of three
        '{ph: 2'd1, a: 32'h100, pos: 4'd3, rdy: 1'b1, hit: 1'b1, d: 32'h33, req: 4'd8},  // R8 skips slot 3
        '{ph: 2'd1, a: 32'h200, pos: 4'd4, rdy: 1'b1, hit: 1'b1, d: 32'h22, req: 4'd8}   // R8
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(input logic [IW-1:0] exp_slot, input string req);
        alloc_req = 1'b1;
        #1;
        chk(alloc_gnt == 1'b1, req, 32'(alloc_gnt), 32'h1);
        chk(alloc_slot == exp_slot, req, 32'(alloc_slot), 32'(exp_slot));
        cyc();
        alloc_req = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] a, input logic [PW-1:0] p,
                           input logic er, input logic eh, input logic [31:0] ed, input string req);
        ld_addr = a;
        ld_pos  = p;
        #1;
        chk(ld_ready == er, req, 32'(ld_ready), 32'(er));
        chk(ld_hit == eh, req, 32'(ld_hit), 32'(eh));
        if (eh) chk(ld_data == ed, req, ld_data, ed);
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL R1: watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(dc_wr_valid == 1'b0, "R1", 32'(dc_wr_valid), 32'h0);
        do_load(32'h100, 4'd0, 1'b1, 1'b0, 32'h0, "R1");

        // R2 in-order allocation of four stores
        for (int k = 0; k < 4; k++) do_alloc(IW'(k), "R2");

        // R4 commit refused while head lacks address and data
        cmt_req = 1'b1; cyc(); cmt_req = 1'b0; cyc();
        chk(dc_wr_valid == 1'b0, "R4", 32'(dc_wr_valid), 32'h0);

        // R3 both orders: slot0 address first, slot1 data first
        sa_we = 1; sa_slot = 0; sa_addr = 32'h100;
        sd_we = 1; sd_slot = 1; sd_data = 32'h22;
        cyc();
        sa_slot = 1; sa_addr = 32'h200;
        sd_slot = 0; sd_data = 32'h11;
        cyc();
        sd_we = 0; sa_slot = 2; sa_addr = 32'h100;
        cyc();
        sa_we = 0;

        for (int r = 0; r < 10; r++) begin
            if (r == 7) begin
                sd_we = 1; sd_slot = 2; sd_data = 32'h33;
                sa_we = 1; sa_slot = 3; sa_addr = 32'h100;
                cyc();
                sd_slot = 3; sd_data = 32'h44; sa_we = 0;
                cyc();
                sd_we = 0;
            end
            do_load(TBL[r].a, TBL[r].pos, TBL[r].rdy, TBL[r].hit, TBL[r].d,
                    $sformatf("R%0d row %0d", TBL[r].req, r));
        end

        // R4 commit of a complete head, visible next cycle
        cmt_req = 1'b1; cyc(); cmt_req = 1'b0;
        chk(dc_wr_valid == 1'b1, "R4", 32'(dc_wr_valid), 32'h1);
        chk(dc_wr_addr == 32'h100, "R5", dc_wr_addr, 32'h100);
        chk(dc_wr_data == 32'h11, "R5", dc_wr_data, 32'h11);

        // R3 write to a committed slot is ignored
        sd_we = 1; sd_slot = 0; sd_data = 32'h99; cyc(); sd_we = 0; #1;
        chk(dc_wr_data == 32'h11, "R3", dc_wr_data, 32'h11);

        // R5 cache refusal holds, acceptance removes
        cyc();
        chk(dc_wr_valid == 1'b1, "R5", 32'(dc_wr_valid), 32'h1);
        dc_wr_ready = 1'b1; cyc(); dc_wr_ready = 1'b0;
        chk(dc_wr_valid == 1'b0, "R5", 32'(dc_wr_valid), 32'h0);

        // R2 fill up with wrap: slots 4..7 then 0
        for (int k = 4; k < 9; k++) do_alloc(IW'(k), "R2");
        sa_we = 1; sa_slot = 4; sa_addr = 32'h100;
        sd_we = 1; sd_slot = 4; sd_data = 32'h88;
        cyc(); sa_we = 0; sd_we = 0;
        alloc_req = 1'b1; #1;
        chk(alloc_gnt == 1'b0, "R2", 32'(alloc_gnt), 32'h0);
        alloc_req = 1'b0;

        // R6 keep up to slot 3
        abort_req = 1; abort_all = 0; abort_keep = 3; cyc(); abort_req = 0; #1;
        chk(alloc_slot == 3'd4, "R6", 32'(alloc_slot), 32'h4);
        do_alloc(3'd4, "R6");
        do_load(32'h100, alloc_pos, 1'b0, 1'b0, 32'h0, "R6");

        // R12 abort beats allocation
        alloc_req = 1; abort_req = 1; abort_all = 0; abort_keep = 4; #1;
        chk(alloc_gnt == 1'b0, "R12", 32'(alloc_gnt), 32'h0);
        cyc(); alloc_req = 0; abort_req = 0; #1;
        chk(alloc_slot == 3'd5, "R12", 32'(alloc_slot), 32'h5);

        // R7 commit slot 1 then flush all speculative entries
        cmt_req = 1; cyc(); cmt_req = 0;
        abort_req = 1; abort_all = 1; cyc(); abort_req = 0; abort_all = 0; #1;
        chk(alloc_slot == 3'd2, "R7", 32'(alloc_slot), 32'h2);
        chk(dc_wr_valid == 1'b1, "R7", 32'(dc_wr_valid), 32'h1);
        chk(dc_wr_data == 32'h22, "R7", dc_wr_data, 32'h22);
        do_load(32'h200, alloc_pos, 1'b1, 1'b1, 32'h22, "R8 committed entry");
        do_load(32'h100, alloc_pos, 1'b1, 1'b0, 32'h0, "R7");
        dc_wr_ready = 1'b1; cyc(); dc_wr_ready = 1'b0;
        chk(dc_wr_valid == 1'b0, "R5", 32'(dc_wr_valid), 32'h0);
        do_load(32'h200, alloc_pos, 1'b1, 1'b0, 32'h0, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule